// File: doc/BRIEF.md
# DMA Parameter-Set Event Sequencer

This block holds the live three-dimensional count state of one DMA channel's parameter set. A parameter set is loaded through a single-cycle load port. After that, each synchronization event turns the current position into one transfer request for a downstream transfer engine. In array mode a request covers one array of `acnt` bytes. In frame mode it covers `bcnt` arrays of `acnt` bytes. The transfer engine only sees two dimensions per request, so the third count (frames) is stepped here.

After each issued request the block advances the addresses and counts for the next event. It raises a final completion pulse when the request that exhausts the frame count is accepted. A chain-trigger pulse, which can start another channel, follows the final completion or, if enabled, every completion. The block also classifies the set on every event:
- A partly-zero set completes at once with no data movement.
- An all-zero set raises an error.

Events that arrive while a request waits for acceptance are held in a single pending slot. Overflowing that slot raises a missed-event error.

Top module: `dma_evt_seq`

## Requirements
- R1: After reset there is no request, and every pulse and error output is low. A load captures the set, cancels any outstanding request, and clears the pending slot and both errors. A load wins over an event in the same cycle, which is then dropped.
- R2: In array mode (`ld_ab_mode_i`=0), a serviced event issues one request with `req_bcnt_o`=1, `req_acnt_o` equal to the loaded `acnt`, and the current source and destination addresses.
- R3: In array mode, after each request the addresses advance by the signed B-index and the remaining array count decrements. After the last array of a frame they advance by the signed C-index instead, the array count reloads, and the frame count decrements.
- R4: In frame mode (`ld_ab_mode_i`=1), each request carries `req_bcnt_o` equal to the loaded `bcnt`. Afterwards the addresses advance by the signed C-index and the frame count decrements.
- R5: `req_valid_o` rises the cycle after the event is sampled. The request fields stay stable until `req_ready_i` is seen high with `req_valid_o`.
- R6: `done_o` is a one-cycle pulse in the cycle after acceptance of the request that exhausts the frame count. No other request produces it.
- R7: With chain enable set, `chain_o` pulses with every final completion. If the intermediate enable is also set, it pulses on every request completion. With chain enable clear it never pulses.
- R8: A set whose acnt, remaining bcnt and remaining ccnt are partly but not all zero completes on an event. It pulses `done_o` (and `chain_o` when enabled) the next cycle, with no request and no error. A fully consumed set is such a set.
- R9: An event on a set whose three counts are all zero sets `null_err_o`, which stays high until the next load. No request and no completion follow.
- R10: An event arriving while a request is outstanding is held as one pending event and serviced once the request is accepted. Another event arriving while the pending slot is full is dropped and sets `miss_err_o`, which stays high until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load the parameter set from the ld_* inputs |
| ld_src_i | input | ADDR_W | Source start address |
| ld_dst_i | input | ADDR_W | Destination start address |
| ld_acnt_i | input | CNT_W | Bytes per array |
| ld_bcnt_i | input | CNT_W | Arrays per frame |
| ld_ccnt_i | input | CNT_W | Frames per block |
| ld_src_bidx_i | input | IDX_W | Signed source step between arrays |
| ld_dst_bidx_i | input | IDX_W | Signed destination step between arrays |
| ld_src_cidx_i | input | IDX_W | Signed source step between frames |
| ld_dst_cidx_i | input | IDX_W | Signed destination step between frames |
| ld_ab_mode_i | input | 1 | 1: frame per event, 0: array per event |
| ld_itc_en_i | input | 1 | Chain on every completion |
| ld_chain_en_i | input | 1 | Chain trigger enable |
| evt_i | input | 1 | Synchronization event |
| req_valid_o | output | 1 | Transfer request valid |
| req_ready_i | input | 1 | Transfer request accepted |
| req_src_o | output | ADDR_W | Request source address |
| req_dst_o | output | ADDR_W | Request destination address |
| req_acnt_o | output | CNT_W | Request bytes per array |
| req_bcnt_o | output | CNT_W | Request array count |
| req_src_bidx_o | output | IDX_W | Request source array step |
| req_dst_bidx_o | output | IDX_W | Request destination array step |
| done_o | output | 1 | Final completion pulse |
| chain_o | output | 1 | Chain trigger pulse |
| null_err_o | output | 1 | Null set error, sticky until load |
| miss_err_o | output | 1 | Missed event error, sticky until load |

## Verification
Address or count errors show up at the first wrong request. The cause can be a missed reload at a frame boundary, an index applied with the wrong sign, or a count decremented in the wrong place. The scoreboard catches the bad address or count one cycle after the event that issued it.

A wrong frame count shows up as `done_o` missing or arriving early, one cycle after a request is accepted. It also shows up when a post-completion event fails to behave as a dummy. A corrupted pending slot either loses a request, which leaves the expected queue non-empty at the end, or raises `miss_err_o` within the cycle of the extra event.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SET_ACTIVE = 2'd0,
    SET_DUMMY  = 2'd1,
    SET_NULL   = 2'd2
  } set_kind_e;
endpackage

// File: rtl/dma_seq_classify.sv
module dma_seq_classify
  import dma_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] acnt_i,
  input  logic [CNT_W-1:0] bcnt_i,
  input  logic [CNT_W-1:0] ccnt_i,
  output set_kind_e        kind_o
);
  logic [2:0] zero;

  assign zero = {acnt_i == '0, bcnt_i == '0, ccnt_i == '0};

  always_comb begin
    if (&zero)      kind_o = SET_NULL;
    else if (|zero) kind_o = SET_DUMMY;
    else            kind_o = SET_ACTIVE;
  end
endmodule

// File: rtl/dma_seq_cnt.sv
module dma_seq_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             ab_mode_i,
  input  logic [CNT_W-1:0] bcnt_i,
  input  logic [CNT_W-1:0] bcnt_rld_i,
  input  logic [CNT_W-1:0] ccnt_i,
  output logic [CNT_W-1:0] bcnt_nxt_o,
  output logic [CNT_W-1:0] ccnt_nxt_o,
  output logic             use_cidx_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic frame_end;

  assign frame_end = ab_mode_i || (bcnt_i == ONE);
  assign use_cidx_o = frame_end;
  assign last_o = frame_end && (ccnt_i == ONE);

  always_comb begin
    bcnt_nxt_o = bcnt_i;
    ccnt_nxt_o = ccnt_i;
    if (ab_mode_i) begin
      ccnt_nxt_o = ccnt_i - ONE;
    end else if (frame_end) begin
      bcnt_nxt_o = bcnt_rld_i;
      ccnt_nxt_o = ccnt_i - ONE;
    end else begin
      bcnt_nxt_o = bcnt_i - ONE;
    end
  end
endmodule

// File: rtl/dma_seq_addr_step.sv
module dma_seq_addr_step #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [IDX_W-1:0]  bidx_i,
  input  logic [IDX_W-1:0]  cidx_i,
  input  logic              use_cidx_i,
  output logic [ADDR_W-1:0] addr_nxt_o
);
  logic [IDX_W-1:0]  step;
  logic [ADDR_W-1:0] step_ext;

  assign step     = use_cidx_i ? cidx_i : bidx_i;
  assign step_ext = ADDR_W'(signed'(step));
  assign addr_nxt_o = addr_i + step_ext;
endmodule

// File: rtl/dma_evt_seq.sv
module dma_evt_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned IDX_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] ld_src_i,
  input  logic [ADDR_W-1:0] ld_dst_i,
  input  logic [CNT_W-1:0]  ld_acnt_i,
  input  logic [CNT_W-1:0]  ld_bcnt_i,
  input  logic [CNT_W-1:0]  ld_ccnt_i,
  input  logic [IDX_W-1:0]  ld_src_bidx_i,
  input  logic [IDX_W-1:0]  ld_dst_bidx_i,
  input  logic [IDX_W-1:0]  ld_src_cidx_i,
  input  logic [IDX_W-1:0]  ld_dst_cidx_i,
  input  logic              ld_ab_mode_i,
  input  logic              ld_itc_en_i,
  input  logic              ld_chain_en_i,
  input  logic              evt_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_src_o,
  output logic [ADDR_W-1:0] req_dst_o,
  output logic [CNT_W-1:0]  req_acnt_o,
  output logic [CNT_W-1:0]  req_bcnt_o,
  output logic [IDX_W-1:0]  req_src_bidx_o,
  output logic [IDX_W-1:0]  req_dst_bidx_o,
  output logic              done_o,
  output logic              chain_o,
  output logic              null_err_o,
  output logic              miss_err_o
);
  localparam int unsigned NPORT = 2; // 0: source, 1: destination
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // live parameter state
  logic [ADDR_W-1:0] addr_q   [NPORT];
  logic [IDX_W-1:0]  bidx_q   [NPORT];
  logic [IDX_W-1:0]  cidx_q   [NPORT];
  logic [ADDR_W-1:0] addr_nxt [NPORT];
  logic [CNT_W-1:0]  acnt_q, bcnt_q, bcnt_rld_q, ccnt_q;
  logic              ab_q, itc_q, chen_q;

  // request and status state
  logic              req_valid_q, req_last_q;
  logic [ADDR_W-1:0] req_src_q, req_dst_q;
  logic [CNT_W-1:0]  req_acnt_q, req_bcnt_q;
  logic [IDX_W-1:0]  req_sb_q, req_db_q;
  logic              pend_q, null_err_q, miss_err_q, done_q, chain_q;

  logic [CNT_W-1:0]  bcnt_nxt, ccnt_nxt;
  logic              use_cidx, last_nxt;
  set_kind_e         kind;
  logic              service, accept, miss;

  assign service = (evt_i || pend_q) && !req_valid_q && !load_i;
  assign accept  = req_valid_q && req_ready_i;
  assign miss    = evt_i && req_valid_q && pend_q && !load_i;

  dma_seq_classify #(.CNT_W(CNT_W)) classify_i (
    .acnt_i (acnt_q),
    .bcnt_i (bcnt_q),
    .ccnt_i (ccnt_q),
    .kind_o (kind)
  );

  dma_seq_cnt #(.CNT_W(CNT_W)) cnt_i (
    .ab_mode_i  (ab_q),
    .bcnt_i     (bcnt_q),
    .bcnt_rld_i (bcnt_rld_q),
    .ccnt_i     (ccnt_q),
    .bcnt_nxt_o (bcnt_nxt),
    .ccnt_nxt_o (ccnt_nxt),
    .use_cidx_o (use_cidx),
    .last_o     (last_nxt)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [ADDR_W-1:0] ld_addr;
    logic [IDX_W-1:0]  ld_bidx, ld_cidx;

    assign ld_addr = (p == 0) ? ld_src_i      : ld_dst_i;
    assign ld_bidx = (p == 0) ? ld_src_bidx_i : ld_dst_bidx_i;
    assign ld_cidx = (p == 0) ? ld_src_cidx_i : ld_dst_cidx_i;

    dma_seq_addr_step #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) step_i (
      .addr_i     (addr_q[p]),
      .bidx_i     (bidx_q[p]),
      .cidx_i     (cidx_q[p]),
      .use_cidx_i (use_cidx),
      .addr_nxt_o (addr_nxt[p])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[p] <= '0;
        bidx_q[p] <= '0;
        cidx_q[p] <= '0;
      end else if (load_i) begin
        addr_q[p] <= ld_addr;
        bidx_q[p] <= ld_bidx;
        cidx_q[p] <= ld_cidx;
      end else if (service && kind == SET_ACTIVE) begin
        addr_q[p] <= addr_nxt[p];
      end
    end
  end

  // counts and mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acnt_q     <= '0;
      bcnt_q     <= '0;
      bcnt_rld_q <= '0;
      ccnt_q     <= '0;
      ab_q       <= 1'b0;
      itc_q      <= 1'b0;
      chen_q     <= 1'b0;
    end else if (load_i) begin
      acnt_q     <= ld_acnt_i;
      bcnt_q     <= ld_bcnt_i;
      bcnt_rld_q <= ld_bcnt_i;
      ccnt_q     <= ld_ccnt_i;
      ab_q       <= ld_ab_mode_i;
      itc_q      <= ld_itc_en_i;
      chen_q     <= ld_chain_en_i;
    end else if (service && kind == SET_ACTIVE) begin
      bcnt_q <= bcnt_nxt;
      ccnt_q <= ccnt_nxt;
    end
  end

  // request register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_valid_q <= 1'b0;
      req_last_q  <= 1'b0;
      req_src_q   <= '0;
      req_dst_q   <= '0;
      req_acnt_q  <= '0;
      req_bcnt_q  <= '0;
      req_sb_q    <= '0;
      req_db_q    <= '0;
    end else if (load_i) begin
      req_valid_q <= 1'b0;
      req_last_q  <= 1'b0;
    end else if (service && kind == SET_ACTIVE) begin
      req_valid_q <= 1'b1;
      req_last_q  <= last_nxt;
      req_src_q   <= addr_q[0];
      req_dst_q   <= addr_q[1];
      req_acnt_q  <= acnt_q;
      req_bcnt_q  <= ab_q ? bcnt_rld_q : ONE;
      req_sb_q    <= bidx_q[0];
      req_db_q    <= bidx_q[1];
    end else if (accept) begin
      req_valid_q <= 1'b0;
    end
  end

  // pending slot, errors, completion pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      null_err_q <= 1'b0;
      miss_err_q <= 1'b0;
      done_q     <= 1'b0;
      chain_q    <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      chain_q <= 1'b0;
      if (load_i) begin
        pend_q     <= 1'b0;
        null_err_q <= 1'b0;
        miss_err_q <= 1'b0;
      end else begin
        if (service) begin
          // a serviced pending event frees the slot for a new one
          pend_q <= pend_q && evt_i;
          unique case (kind)
            SET_NULL:  null_err_q <= 1'b1;
            SET_DUMMY: begin
              done_q  <= 1'b1;
              chain_q <= chen_q;
            end
            default: ;
          endcase
        end else if (evt_i && req_valid_q) begin
          pend_q <= 1'b1;
        end
        if (miss) miss_err_q <= 1'b1;
        if (accept) begin
          done_q  <= req_last_q;
          chain_q <= chen_q && (req_last_q || itc_q);
        end
      end
    end
  end

  assign req_valid_o    = req_valid_q;
  assign req_src_o      = req_src_q;
  assign req_dst_o      = req_dst_q;
  assign req_acnt_o     = req_acnt_q;
  assign req_bcnt_o     = req_bcnt_q;
  assign req_src_bidx_o = req_sb_q;
  assign req_dst_bidx_o = req_db_q;
  assign done_o         = done_q;
  assign chain_o        = chain_q;
  assign null_err_o     = null_err_q;
  assign miss_err_o     = miss_err_q;
endmodule

// File: rtl/dma_evt_seq_chk.sv
module dma_evt_seq_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              evt_i,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_src_o,
  input logic [ADDR_W-1:0] req_dst_o,
  input logic [CNT_W-1:0]  req_acnt_o,
  input logic [CNT_W-1:0]  req_bcnt_o,
  input logic              done_o,
  input logic              chain_o,
  input logic              null_err_o,
  input logic              miss_err_o,
  input logic              pend_q,
  input logic              ab_q,
  input logic              itc_q
);
  assert_load_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !req_valid_o && !null_err_o && !miss_err_o && !done_o);

  assert_a_one_array_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !ab_q |-> req_bcnt_o == CNT_W'(1));

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i && !load_i |=>
      req_valid_o && $stable(req_src_o) && $stable(req_dst_o) && $stable(req_bcnt_o));

  assert_done_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(req_valid_o && req_ready_i) || $past(evt_i || pend_q));

  assert_chain_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_o && !itc_q |-> done_o);

  assert_no_empty_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> req_acnt_o != '0 && req_bcnt_o != '0);

  assert_null_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(null_err_o) |-> $past(evt_i || pend_q));

  assert_miss_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(miss_err_o) |-> $past(evt_i && pend_q));
endmodule

bind dma_evt_seq dma_evt_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .evt_i       (evt_i),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_src_o   (req_src_o),
  .req_dst_o   (req_dst_o),
  .req_acnt_o  (req_acnt_o),
  .req_bcnt_o  (req_bcnt_o),
  .done_o      (done_o),
  .chain_o     (chain_o),
  .null_err_o  (null_err_o),
  .miss_err_o  (miss_err_o),
  .pend_q      (pend_q),
  .ab_q        (ab_q),
  .itc_q       (itc_q)
);

// File: tb/dma_evt_seq_tb_top.sv
module dma_evt_seq_tb_top;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int IW = 16;

  typedef struct {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
    logic [CW-1:0] acnt;
    logic [CW-1:0] bcnt;
    bit            last;
    bit            chain;
  } item_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b0;
  logic [AW-1:0] ld_src_i = '0, ld_dst_i = '0;
  logic [CW-1:0] ld_acnt_i = '0, ld_bcnt_i = '0, ld_ccnt_i = '0;
  logic [IW-1:0] ld_src_bidx_i = '0, ld_dst_bidx_i = '0, ld_src_cidx_i = '0, ld_dst_cidx_i = '0;
  logic ld_ab_mode_i = 1'b0, ld_itc_en_i = 1'b0, ld_chain_en_i = 1'b0;
  logic evt_i = 1'b0;
  logic req_ready_i = 1'b1;
  logic req_valid_o;
  logic [AW-1:0] req_src_o, req_dst_o;
  logic [CW-1:0] req_acnt_o, req_bcnt_o;
  logic [IW-1:0] req_src_bidx_o, req_dst_bidx_o;
  logic done_o, chain_o, null_err_o, miss_err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  item_t exp_q[$];
  bit    pend_chk = 0;
  item_t pend_item;

  always #5 clk_i = ~clk_i;

  dma_evt_seq #(.ADDR_W(AW), .CNT_W(CW), .IDX_W(IW)) dut_i (
    .clk_i, .rst_ni, .load_i,
    .ld_src_i, .ld_dst_i, .ld_acnt_i, .ld_bcnt_i, .ld_ccnt_i,
    .ld_src_bidx_i, .ld_dst_bidx_i, .ld_src_cidx_i, .ld_dst_cidx_i,
    .ld_ab_mode_i, .ld_itc_en_i, .ld_chain_en_i,
    .evt_i, .req_valid_o, .req_ready_i,
    .req_src_o, .req_dst_o, .req_acnt_o, .req_bcnt_o,
    .req_src_bidx_o, .req_dst_bidx_o,
    .done_o, .chain_o, .null_err_o, .miss_err_o
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // monitor: compares each accepted request, then the completion pulses one cycle later
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (pend_chk) begin
        pend_chk = 0;
        chk(done_o == pend_item.last, "R6", "done after accept", 64'(done_o), 64'(pend_item.last));
        chk(chain_o == pend_item.chain, "R7", "chain after accept", 64'(chain_o), 64'(pend_item.chain));
      end
      if (req_valid_o && req_ready_i) begin
        if (exp_q.size() == 0) begin
          chk(0, "R5", "unexpected request", 64'(req_src_o), 64'(0));
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(req_src_o == e.src, "R3", "req source", 64'(req_src_o), 64'(e.src));
          chk(req_dst_o == e.dst, "R3", "req destination", 64'(req_dst_o), 64'(e.dst));
          chk(req_acnt_o == e.acnt, "R2", "req acnt", 64'(req_acnt_o), 64'(e.acnt));
          chk(req_bcnt_o == e.bcnt, "R4", "req bcnt", 64'(req_bcnt_o), 64'(e.bcnt));
          pend_item = e;
          pend_chk = 1;
        end
      end
    end
  end

  task automatic load_set(input logic [AW-1:0] s, input logic [AW-1:0] d,
                          input int a, input int b, input int c,
                          input int sb, input int db, input int sc, input int dc,
                          input bit ab, input bit itc, input bit ch);
    @(negedge clk_i);
    ld_src_i = s; ld_dst_i = d;
    ld_acnt_i = CW'(a); ld_bcnt_i = CW'(b); ld_ccnt_i = CW'(c);
    ld_src_bidx_i = IW'(sb); ld_dst_bidx_i = IW'(db);
    ld_src_cidx_i = IW'(sc); ld_dst_cidx_i = IW'(dc);
    ld_ab_mode_i = ab; ld_itc_en_i = itc; ld_chain_en_i = ch;
    load_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  task automatic fire();
    @(negedge clk_i);
    evt_i = 1'b1;
    @(negedge clk_i);
    evt_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // expected requests of a whole set, built from the stepping rules of R2..R4
  task automatic push_set(input logic [AW-1:0] s0, input logic [AW-1:0] d0,
                          input int a, input int b, input int c,
                          input int sb, input int db, input int sc, input int dc,
                          input bit ab, input bit itc, input bit ch);
    logic [AW-1:0] s, d;
    s = s0; d = d0;
    for (int ci = 0; ci < c; ci++) begin
      for (int bi = 0; bi < (ab ? 1 : b); bi++) begin
        item_t it;
        bit fend;
        fend = ab || (bi == b - 1);
        it.src = s; it.dst = d; it.acnt = CW'(a);
        it.bcnt = ab ? CW'(b) : CW'(1);
        it.last = fend && (ci == c - 1);
        it.chain = ch && (it.last || itc);
        exp_q.push_back(it);
        s = s + AW'(fend ? sc : sb);
        d = d + AW'(fend ? dc : db);
      end
    end
  endtask

  task automatic run_events(input int n);
    for (int i = 0; i < n; i++) begin
      fire();
      idle(3);
    end
  endtask

  task automatic dummy_event(input bit exp_chain, input string rq);
    fire();
    chk(done_o == 1'b1, rq, "dummy done", 64'(done_o), 64'(1));
    chk(chain_o == exp_chain, rq, "dummy chain", 64'(chain_o), 64'(exp_chain));
    chk(req_valid_o == 1'b0, rq, "dummy no request", 64'(req_valid_o), 64'(0));
    chk(null_err_o == 1'b0, rq, "dummy no error", 64'(null_err_o), 64'(0));
    @(negedge clk_i);
    chk(done_o == 1'b0, rq, "dummy pulse width", 64'(done_o), 64'(0));
    idle(2);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: reset state
    chk(req_valid_o == 0, "R1", "reset valid", 64'(req_valid_o), 64'(0));
    chk({done_o, chain_o, null_err_o, miss_err_o} == 4'b0, "R1", "reset flags",
        64'({done_o, chain_o, null_err_o, miss_err_o}), 64'(0));

    // R9: the reset set has all counts zero
    fire();
    chk(null_err_o == 1, "R9", "null after reset", 64'(null_err_o), 64'(1));
    chk(req_valid_o == 0 && done_o == 0, "R9", "null no request/done",
        64'({req_valid_o, done_o}), 64'(0));
    idle(2);
    chk(null_err_o == 1, "R9", "null sticky", 64'(null_err_o), 64'(1));

    // R2/R3/R6/R7: array mode, negative destination frame step, chain on final only
    load_set(32'h1000, 32'h2000, 4, 3, 2, 4, 8, 'h100, -'h40, 0, 0, 1);
    chk(null_err_o == 0, "R1", "load clears null", 64'(null_err_o), 64'(0));
    push_set(32'h1000, 32'h2000, 4, 3, 2, 4, 8, 'h100, -'h40, 0, 0, 1);
    run_events(6);
    chk(exp_q.size() == 0, "R3", "array set drained", 64'(exp_q.size()), 64'(0));
    // R8: consumed set behaves as dummy
    dummy_event(1'b1, "R8");

    // R4/R7: frame mode, intermediate chain enabled
    load_set(32'h8000, 32'h9000, 8, 4, 3, 8, 8, 'h20, 'h40, 1, 1, 1);
    push_set(32'h8000, 32'h9000, 8, 4, 3, 8, 8, 'h20, 'h40, 1, 1, 1);
    run_events(3);
    chk(exp_q.size() == 0, "R4", "frame set drained", 64'(exp_q.size()), 64'(0));

    // R7: chain disabled
    load_set(32'h100, 32'h200, 2, 2, 1, -2, 2, 0, 0, 1, 1, 0);
    push_set(32'h100, 32'h200, 2, 2, 1, -2, 2, 0, 0, 1, 1, 0);
    run_events(1);
    dummy_event(1'b0, "R7");

    // R8: partly zero set
    load_set(32'h40, 32'h80, 0, 2, 1, 1, 1, 1, 1, 0, 0, 1);
    dummy_event(1'b1, "R8");

    // R9: null set loaded explicitly
    load_set(32'h40, 32'h80, 0, 0, 0, 1, 1, 1, 1, 1, 0, 0);
    fire();
    chk(null_err_o == 1 && done_o == 0, "R9", "loaded null set",
        64'({null_err_o, done_o}), 64'(2));

    // R10/R5: pending and missed events with the engine stalled
    load_set(32'hA000, 32'hB000, 2, 1, 3, 0, 0, 'h10, 'h10, 1, 0, 0);
    push_set(32'hA000, 32'hB000, 2, 1, 2, 0, 0, 'h10, 'h10, 1, 0, 0);
    exp_q[1].last = 0;
    @(negedge clk_i);
    req_ready_i = 1'b0;
    evt_i = 1'b1;
    @(negedge clk_i);
    chk(req_valid_o == 1, "R5", "request after event", 64'(req_valid_o), 64'(1));
    @(negedge clk_i);
    chk(miss_err_o == 0, "R10", "one pending no miss", 64'(miss_err_o), 64'(0));
    @(negedge clk_i);
    evt_i = 1'b0;
    chk(miss_err_o == 1, "R10", "second pending miss", 64'(miss_err_o), 64'(1));
    chk(req_src_o == 32'hA000, "R5", "held source", 64'(req_src_o), 64'(32'hA000));
    req_ready_i = 1'b1;
    idle(6);
    chk(exp_q.size() == 0, "R10", "pending serviced once", 64'(exp_q.size()), 64'(0));
    chk(req_valid_o == 0, "R10", "dropped event not issued", 64'(req_valid_o), 64'(0));

    // R1: load cancels an outstanding request and clears miss
    req_ready_i = 1'b0;
    fire();
    chk(req_valid_o == 1, "R1", "stalled request", 64'(req_valid_o), 64'(1));
    load_set(32'hC000, 32'hD000, 4, 2, 2, 4, 4, 8, 8, 0, 0, 0);
    chk(req_valid_o == 0 && miss_err_o == 0, "R1", "load cancel",
        64'({req_valid_o, miss_err_o}), 64'(0));
    // R1: load and event in the same cycle
    @(negedge clk_i);
    load_i = 1'b1; evt_i = 1'b1;
    @(negedge clk_i);
    load_i = 1'b0; evt_i = 1'b0;
    @(negedge clk_i);
    chk(req_valid_o == 0, "R1", "event dropped by load", 64'(req_valid_o), 64'(0));
    req_ready_i = 1'b1;
    push_set(32'hC000, 32'hD000, 4, 2, 2, 4, 4, 8, 8, 0, 0, 0);
    run_events(4);
    chk(exp_q.size() == 0, "R3", "reloaded set drained", 64'(exp_q.size()), 64'(0));

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule